// File: doc/BRIEF.md
# Holdover-Capable Digitally Controlled Oscillator

This block is a phase-accumulator oscillator that runs from a 20 MHz master clock. Each cycle it adds a frequency word to a wrapping accumulator. The carry out of that addition becomes a one-cycle output clock enable, so the average enable rate is the word divided by two to the accumulator width, times the master clock. An upstream phase detector and loop filter steer the oscillator with a signed correction word. In the locked state that word is added to a fixed nominal increment every cycle, so the output follows the reference in both frequency and phase.

When the reference is lost, the block can be switched to hold its frequency. While locked, it samples the active frequency word into a two-deep history once per sample period (30 ms at the default setting). In hold it replays the older of the two entries, which is always between one and two periods old. A disturbance just before the reference failed is therefore not carried into the held frequency. A third state ignores the loop and runs at the nominal increment, so its accuracy is that of the master clock. The accumulator is never cleared on a mode change, so a switch between modes produces no phase step.

Top module: `dco_holdover`

## Requirements
- R1: A synchronous reset (rst_i high at a clock edge) clears the accumulator and the history and selects the free-running state; after that edge clk_en_o is 0 and freq_o equals NOM_INC.
- R2: With mode_i = 2'b00 (track), freq_o equals NOM_INC plus corr_i, with corr_i read as a CORR_W-bit two's complement value, sign-extended to ACC_W bits, and the sum taken modulo 2^ACC_W.
- R3: On each edge the accumulator adds the active frequency word modulo 2^ACC_W, and clk_en_o is high for the cycle after exactly those edges where the addition overflowed.
- R4: With mode_i = 2'b10 or 2'b11 (free-run), freq_o equals NOM_INC and corr_i has no effect.
- R5: With mode_i = 2'b01 (hold) and at least two history samples taken, freq_o equals the older of the two stored words.
- R6: In hold with fewer than two history samples taken since reset, freq_o equals NOM_INC.
- R7: History samples are taken only while the registered mode is track, so hold or free-run intervals leave the stored words unchanged.
- R8: A change on mode_i is registered on the next clock edge, and freq_o reflects the new mode from that edge on; the accumulator carries on without a phase reset.
- R9: A prescaler counts SAMPLE_PERIOD master-clock cycles starting from reset. On the edge that completes each count, if the registered mode is track, the active word is pushed into the history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_i | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | 00 track, 01 hold, 10/11 free-run |
| corr_i | input | CORR_W | Signed frequency correction from the loop filter |
| clk_en_o | output | 1 | Accumulator carry, one cycle per output period |
| freq_o | output | ACC_W | Frequency word currently applied |

## Verification
The bench builds the block with an 8-bit accumulator, a 6-bit correction and a nominal increment of 64. With these values a carry falls every few cycles, and the accumulator overflows under both positive and negative corrections. SAMPLE_PERIOD is set to 5 instead of 600,000, so the history fills, shifts and freezes within a few dozen cycles. This also puts in reach the boundary where hold is entered one cycle before or on the second sample, and hold entered before any sample.

// File: rtl/dco_pkg.sv
package dco_pkg;

    typedef enum logic [1:0] {
        MODE_TRACK = 2'b00,
        MODE_HOLD  = 2'b01,
        MODE_FREE  = 2'b10
    } dco_mode_e;

    // Code 11 folds into free-run.
    function automatic dco_mode_e decode_mode(input logic [1:0] code);
        case (code)
            2'b00:   return MODE_TRACK;
            2'b01:   return MODE_HOLD;
            default: return MODE_FREE;
        endcase
    endfunction

endpackage

// File: rtl/dco_history.sv
module dco_history
    import dco_pkg::*;
#(
    parameter int ACC_W         = 32,
    parameter int SAMPLE_PERIOD = 600000
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  dco_mode_e        mode_q_i,
    input  logic [ACC_W-1:0] track_word_i,
    output logic [ACC_W-1:0] older_o,
    output logic             full_o
);
    localparam int PW = (SAMPLE_PERIOD > 2) ? $clog2(SAMPLE_PERIOD) : 1;
    localparam logic [PW-1:0] LAST = PW'(SAMPLE_PERIOD - 1);

    logic [PW-1:0]    pres_q;
    logic [ACC_W-1:0] newer_q;
    logic [ACC_W-1:0] older_q;
    logic [1:0]       fill_q;
    logic             wrap;
    logic             take;

    assign wrap = (pres_q == LAST);
    assign take = wrap && (mode_q_i == MODE_TRACK);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pres_q  <= '0;
            newer_q <= '0;
            older_q <= '0;
            fill_q  <= '0;
        end else begin
            pres_q <= wrap ? '0 : pres_q + 1'b1;
            if (take) begin
                older_q <= newer_q;
                newer_q <= track_word_i;
                if (fill_q != 2'd2) fill_q <= fill_q + 1'b1;
            end
        end
    end

    assign older_o = older_q;
    assign full_o  = (fill_q == 2'd2);

    AST_HIST_FROZEN: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_q_i != MODE_TRACK) |=> ($stable(older_q) && $stable(newer_q))); // R7

endmodule

// File: rtl/dco_word_sel.sv
module dco_word_sel
    import dco_pkg::*;
#(
    parameter int               ACC_W   = 32,
    parameter int               CORR_W  = 16,
    parameter logic [ACC_W-1:0] NOM_INC = 32'd1717986918
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  dco_mode_e         mode_q_i,
    input  logic [CORR_W-1:0] corr_i,
    input  logic [ACC_W-1:0]  older_i,
    input  logic              full_i,
    output logic [ACC_W-1:0]  track_word_o,
    output logic [ACC_W-1:0]  word_o
);
    localparam int EXT_W = ACC_W - CORR_W;

    logic [ACC_W-1:0] corr_ext;

    assign corr_ext     = {{EXT_W{corr_i[CORR_W-1]}}, corr_i};
    assign track_word_o = NOM_INC + corr_ext;

    always_comb begin
        case (mode_q_i)
            MODE_TRACK: word_o = track_word_o;
            MODE_HOLD:  word_o = full_i ? older_i : NOM_INC;
            default:    word_o = NOM_INC;
        endcase
    end

    AST_HOLD_EMPTY_NOM: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_q_i == MODE_HOLD && !full_i) |-> (word_o == NOM_INC)); // R6

endmodule

// File: rtl/dco_phase_acc.sv
module dco_phase_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [ACC_W-1:0] word_i,
    output logic             carry_o
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum;
    logic             carry_q;

    assign sum = {1'b0, acc_q} + {1'b0, word_i};

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            acc_q   <= '0;
            carry_q <= 1'b0;
        end else begin
            acc_q   <= sum[ACC_W-1:0];
            carry_q <= sum[ACC_W];
        end
    end

    assign carry_o = carry_q;

    AST_CARRY_WRAPS: assert property (@(posedge clk_i) disable iff (rst_i)
        carry_q |-> (acc_q < $past(word_i))); // R3

endmodule

// File: rtl/dco_holdover.sv
module dco_holdover
    import dco_pkg::*;
#(
    parameter int               ACC_W         = 32,
    parameter int               CORR_W        = 16,
    parameter logic [ACC_W-1:0] NOM_INC       = 32'd1717986918,
    parameter int               SAMPLE_PERIOD = 600000
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [1:0]        mode_i,
    input  logic [CORR_W-1:0] corr_i,
    output logic              clk_en_o,
    output logic [ACC_W-1:0]  freq_o
);
    dco_mode_e        mode_q;
    logic [ACC_W-1:0] track_word;
    logic [ACC_W-1:0] older;
    logic             full;
    logic [ACC_W-1:0] word;

    always_ff @(posedge clk_i) begin
        if (rst_i) mode_q <= MODE_FREE;
        else       mode_q <= decode_mode(mode_i);
    end

    dco_history #(.ACC_W(ACC_W), .SAMPLE_PERIOD(SAMPLE_PERIOD)) u_hist (
        .clk_i(clk_i), .rst_i(rst_i), .mode_q_i(mode_q),
        .track_word_i(track_word), .older_o(older), .full_o(full)
    );

    dco_word_sel #(.ACC_W(ACC_W), .CORR_W(CORR_W), .NOM_INC(NOM_INC)) u_sel (
        .clk_i(clk_i), .rst_i(rst_i), .mode_q_i(mode_q), .corr_i(corr_i),
        .older_i(older), .full_i(full), .track_word_o(track_word), .word_o(word)
    );

    dco_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk_i(clk_i), .rst_i(rst_i), .word_i(word), .carry_o(clk_en_o)
    );

    assign freq_o = word;

    AST_TRACK_FOLLOWS: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && $past(mode_i) == 2'b00) |->
        (freq_o == NOM_INC + {{(ACC_W-CORR_W){corr_i[CORR_W-1]}}, corr_i})); // R2

    AST_FREE_NOMINAL: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && $past(mode_i[1])) |-> (freq_o == NOM_INC)); // R4

endmodule

// File: tb/sim_dco_holdover.sv
module sim_dco_holdover;
    localparam int         AW  = 8;
    localparam int         CW  = 6;
    localparam logic [7:0] NOM = 8'd64;
    localparam int         P   = 5;

    typedef struct packed {
        logic [1:0] mode;
        logic [5:0] corr;
        logic [7:0] n;
    } vec_t;

    localparam vec_t VECS [0:9] = '{
        '{2'b10, 6'd5,  8'd6},
        '{2'b01, 6'd3,  8'd4},
        '{2'b00, 6'd10, 8'd12},
        '{2'b00, 6'h39, 8'd7},
        '{2'b01, 6'd20, 8'd6},
        '{2'b11, 6'h3D, 8'd5},
        '{2'b01, 6'd0,  8'd5},
        '{2'b00, 6'h20, 8'd8},
        '{2'b00, 6'd31, 8'd6},
        '{2'b01, 6'd7,  8'd9}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    mode = 2'b10;
    logic [CW-1:0] corr = '0;
    logic          clk_en;
    logic [AW-1:0] freq;

    int checks = 0;
    int fails  = 0;

    logic [1:0]    m_mode;
    logic [AW-1:0] m_acc, m_old, m_new;
    logic          m_carry;
    int            m_cnt, m_pres;

    always #10 clk = ~clk;

    dco_holdover #(.ACC_W(AW), .CORR_W(CW), .NOM_INC(NOM), .SAMPLE_PERIOD(P)) u0 (
        .clk_i(clk), .rst_i(rst), .mode_i(mode), .corr_i(corr),
        .clk_en_o(clk_en), .freq_o(freq)
    );

    function automatic logic [AW-1:0] exp_word(input logic [1:0] md, input logic [CW-1:0] cr);
        if (md == 2'b00)      return NOM + {{(AW-CW){cr[CW-1]}}, cr};
        else if (md == 2'b01) return (m_cnt >= 2) ? m_old : NOM;
        else                  return NOM;
    endfunction

    task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_edge(input logic r, input logic [1:0] md, input logic [CW-1:0] cr);
        logic [AW:0] s;
        logic [AW-1:0] w;
        if (r) begin
            m_acc = '0; m_carry = 1'b0; m_old = '0; m_new = '0;
            m_cnt = 0; m_pres = 0; m_mode = 2'b10;
        end else begin
            w = exp_word(m_mode, cr);
            s = {1'b0, m_acc} + {1'b0, w};
            m_acc = s[AW-1:0];
            m_carry = s[AW];
            if (m_pres == P - 1) begin
                if (m_mode == 2'b00) begin
                    m_old = m_new;
                    m_new = w;
                    if (m_cnt < 2) m_cnt++;
                end
                m_pres = 0;
            end else m_pres++;
            m_mode = (md == 2'b11) ? 2'b10 : md;
        end
    endtask

    task automatic tick(input logic r, input logic [1:0] md, input logic [CW-1:0] cr, input string tg);
        string t;
        rst = r; mode = md; corr = cr;
        @(posedge clk);
        model_edge(r, md, cr);
        @(negedge clk);
        if (tg != "") t = tg;
        else if (m_mode == 2'b00) t = "R2";
        else if (m_mode == 2'b01) t = (m_cnt >= 2) ? "R5" : "R6";
        else t = "R4";
        check(t, freq, exp_word(m_mode, cr));
        check("R3 carry", {7'd0, clk_en}, {7'd0, m_carry});
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected completion");
        checks++; fails++;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [AW-1:0] held;
        @(negedge clk);
        tick(1'b1, 2'b00, 6'd9, "R1");
        check("R1 enable", {7'd0, clk_en}, 8'd0);
        check("R1 word", freq, NOM);

        // vector table walk
        for (int v = 0; v < 10; v++) begin
            for (int k = 0; k < int'(VECS[v].n); k++)
                tick(1'b0, VECS[v].mode, VECS[v].corr, "");
        end

        // R7: hold word survives a free-run interval
        tick(1'b0, 2'b01, 6'd4, "R5");
        held = freq;
        for (int k = 0; k < 7; k++) tick(1'b0, 2'b10, 6'd11, "R4");
        tick(1'b0, 2'b01, 6'd2, "R7");
        check("R7 stored word", freq, held);

        // R8: single-cycle mode changes, no phase reset
        tick(1'b0, 2'b00, 6'd17, "R8");
        tick(1'b0, 2'b10, 6'd17, "R8");
        tick(1'b0, 2'b00, 6'h30, "R8");
        tick(1'b0, 2'b01, 6'h30, "R8");

        // R9: hold entered one cycle before the second sample
        tick(1'b1, 2'b00, 6'd0, "R1");
        for (int k = 0; k < 2*P - 2; k++) tick(1'b0, 2'b00, 6'd1, "R9");
        tick(1'b0, 2'b01, 6'd1, "R9");
        check("R9 one sample", freq, NOM);
        tick(1'b0, 2'b01, 6'd1, "R9");

        // R9: hold entered on the second sample edge
        tick(1'b1, 2'b00, 6'd0, "R1");
        for (int k = 0; k < P; k++) tick(1'b0, 2'b00, 6'd1, "R9");
        for (int k = 0; k < P - 1; k++) tick(1'b0, 2'b00, 6'd2, "R9");
        tick(1'b0, 2'b01, 6'd2, "R9");
        tick(1'b0, 2'b01, 6'd2, "R9");
        check("R9 older sample", freq, NOM + 8'd1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule